// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the test-access logic that sits between a four-wire serial test port and a handful of device pins. It runs the standard sixteen-state TAP state machine on TCK and TMS, holds a four-bit instruction register, and keeps three data registers. The first is a one-bit pass-through stage. The second is a boundary register that covers a small group of input and output pins. The third is a capture register for a chip status word. The active instruction decides which of these registers sits between TDI and TDO.

The active instruction also drives the pin-control side of the block. It selects whether the output pins carry the functional system value or the contents of the boundary update latch. It can disable every output driver at once, and it can request an internal system reset. Board test software uses the block in a fixed order. It first loads pin values with the sample/preload instruction. It then applies them to the board with the external-test or clamp instruction, and it floats the pins with the high-impedance instruction.

Top module: `jtag_bscan_ctrl`

## Requirements
- R1: Driving `trst_n` low puts the controller in Test-Logic-Reset at once. Holding TMS high for five TCK rising edges also reaches Test-Logic-Reset. In that state the active instruction becomes BYPASS (1111), the output update latch is cleared to zero, and the pins return to system mode.
- R2: In Capture-IR the instruction shift register loads 0001, and it shifts LSB first toward TDO. A newly shifted instruction changes the pin controls only at the falling TCK edge in Update-IR. Before that edge, even with the controller parked in Pause-IR, the old instruction stays in force.
- R3: TDO changes on the falling TCK edge. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR and is low in every other state.
- R4: BYPASS (1111) and every code not listed in R5 to R9 put a one-bit register in the path. That register captures 0, so TDO repeats TDI one shift later. None of these codes drives the pins from the latch, floats the pins or requests reset.
- R5: SAMPLE/PRELOAD (0010) puts the boundary register in the path. In Capture-DR it loads `{sys_out, pin_in}`, so `pin_in[0]` is the first bit out. `pad_out` keeps following `sys_out`. In Update-DR the output part of the register (its top `N_OUT` bits) loads the update latch.
- R6: EXTEST (0000) puts the boundary register in the path and drives `pad_out` from the update latch, with `bsr_drive` high. It holds `sys_rst_req` high for as long as it is active. Update-DR also loads the latch under EXTEST.
- R7: HIGHZ (1001) puts the one-bit register in the path. It raises `pads_hiz` and `sys_rst_req`, and `bsr_drive` stays low.
- R8: CLAMP (0110) puts the one-bit register in the path and drives `pad_out` from the update latch with `bsr_drive` high. It requests no reset.
- R9: The status instruction (0100) loads `soc_word` into its own register in Capture-DR and shifts it out LSB first.
- R10: The update latch changes only in Update-DR under SAMPLE/PRELOAD or EXTEST. A data scan under any other instruction leaves the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising TCK edge |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on the falling TCK edge |
| tdo_oe | output | 1 | TDO driver enable, high only in the shift states |
| pin_in | input | N_IN | Values present at the input pins |
| sys_out | input | N_OUT | Functional values headed for the output pins |
| soc_word | input | SOC_W | Chip status word for the status instruction |
| pad_out | output | N_OUT | Value sent to the output pad drivers |
| bsr_drive | output | 1 | High when the pads take the update latch rather than system data |
| pads_hiz | output | 1 | Global output-driver disable |
| sys_rst_req | output | 1 | Internal system reset request |

## Verification
The bench follows each instruction load with a sixteen-bit data scan of random bits. The length of the delay before the TDI bits reappear at TDO shows which register is in the path: one bit for the pass-through stage, eight for the boundary and status registers. The bits shifted out ahead of that point show the captured contents. Random pin, system and status values tell the boundary capture apart from the status capture. Random instruction codes, undefined ones included, run through the whole decode. The directed cases are:
- a preload followed by EXTEST and then CLAMP, which shows that the latch drives the pins;
- a scan under CLAMP, which shows that the latch is left alone;
- a stop in Pause-IR, which shows that the new instruction has not yet taken effect;
- a TMS-high walk into reset and a TRST pulse in the middle of a scan, which show the reset state.

// File: rtl/jtag_bscan_ctrl.sv
`timescale 1ns/1ps
module jtag_bscan_ctrl #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int SOC_W = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] sys_out,
  input  logic [SOC_W-1:0] soc_word,
  output logic [N_OUT-1:0] pad_out,
  output logic             bsr_drive,
  output logic             pads_hiz,
  output logic             sys_rst_req
);
  localparam int BSR_W = N_IN + N_OUT;
  localparam logic [3:0] OP_EXTEST = 4'b0000;
  localparam logic [3:0] OP_SAMPLE = 4'b0010;
  localparam logic [3:0] OP_STATUS = 4'b0100;
  localparam logic [3:0] OP_CLAMP  = 4'b0110;
  localparam logic [3:0] OP_HIGHZ  = 4'b1001;
  localparam logic [3:0] OP_BYPASS = 4'b1111;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t st, st_nx;

  always_comb begin
    case (st)
      TLR:     st_nx = tms ? TLR    : RTI;
      RTI:     st_nx = tms ? SEL_DR : RTI;
      SEL_DR:  st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  st_nx = tms ? UPD_DR : PAU_DR;
      PAU_DR:  st_nx = tms ? EX2_DR : PAU_DR;
      EX2_DR:  st_nx = tms ? UPD_DR : SH_DR;
      UPD_DR:  st_nx = tms ? SEL_DR : RTI;
      SEL_IR:  st_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  st_nx = tms ? UPD_IR : PAU_IR;
      PAU_IR:  st_nx = tms ? EX2_IR : PAU_IR;
      EX2_IR:  st_nx = tms ? UPD_IR : SH_IR;
      default: st_nx = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else         st <= st_nx;

  logic [3:0] ir_sr, ir_act;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)          ir_sr <= 4'b0001;
    else if (st == CAP_IR) ir_sr <= 4'b0001;
    else if (st == SH_IR)  ir_sr <= {tdi, ir_sr[3:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)           ir_act <= OP_BYPASS;
    else if (st == TLR)    ir_act <= OP_BYPASS;
    else if (st == UPD_IR) ir_act <= ir_sr;

  logic sel_bsr, sel_soc;

  always_comb begin
    sel_bsr     = 1'b0;
    sel_soc     = 1'b0;
    bsr_drive   = 1'b0;
    pads_hiz    = 1'b0;
    sys_rst_req = 1'b0;
    case (ir_act)
      OP_EXTEST: begin sel_bsr = 1'b1; bsr_drive = 1'b1; sys_rst_req = 1'b1; end
      OP_SAMPLE: sel_bsr = 1'b1;
      OP_STATUS: sel_soc = 1'b1;
      OP_CLAMP:  bsr_drive = 1'b1;
      OP_HIGHZ:  begin pads_hiz = 1'b1; sys_rst_req = 1'b1; end
      default:   ;
    endcase
  end

  logic             byp;
  logic [BSR_W-1:0] bsr;
  logic [SOC_W-1:0] soc_sr;
  logic [N_OUT-1:0] upd;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp    <= 1'b0;
      bsr    <= '0;
      soc_sr <= '0;
    end else if (st == CAP_DR) begin
      byp <= 1'b0;
      if (sel_bsr) bsr    <= {sys_out, pin_in};
      if (sel_soc) soc_sr <= soc_word;
    end else if (st == SH_DR) begin
      byp <= tdi;
      if (sel_bsr) bsr    <= {tdi, bsr[BSR_W-1:1]};
      if (sel_soc) soc_sr <= {tdi, soc_sr[SOC_W-1:1]};
    end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                     upd <= '0;
    else if (st == TLR)              upd <= '0;
    else if (st == UPD_DR && sel_bsr) upd <= bsr[BSR_W-1:N_IN];

  assign pad_out = bsr_drive ? upd : sys_out;

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == SH_DR) || (st == SH_IR);
      if (st == SH_IR)      tdo <= ir_sr[0];
      else if (st == SH_DR) tdo <= sel_bsr ? bsr[0] : (sel_soc ? soc_sr[0] : byp);
      else                  tdo <= 1'b0;
    end
endmodule

// File: rtl/bscan_chk.sv
`timescale 1ns/1ps
module bscan_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tdo_oe,
  input logic       bsr_drive,
  input logic       pads_hiz,
  input logic       sys_rst_req,
  input logic [3:0] st,
  input logic [3:0] ir_act
);
  localparam logic [3:0] S_TLR = 4'd0, S_SHDR = 4'd4, S_SHIR = 4'd11, S_UPIR = 4'd15;

  AST_TLR_FORCES_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (ir_act == 4'b1111)); // R1
  AST_IR_HOLDS_OUTSIDE_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_UPIR && st != S_TLR) |-> $stable(ir_act)); // R2
  AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == S_SHDR || st == S_SHIR)); // R3
  AST_HIZ_WITH_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    pads_hiz |-> sys_rst_req); // R7
  AST_HIZ_NOT_LATCHED: assert property (@(posedge tck) disable iff (!trst_n)
    pads_hiz |-> !bsr_drive); // R7
endmodule

bind jtag_bscan_ctrl bscan_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tdo_oe(tdo_oe), .bsr_drive(bsr_drive),
  .pads_hiz(pads_hiz), .sys_rst_req(sys_rst_req), .st(st), .ir_act(ir_act)
);

// File: tb/sim_jtag_bscan_ctrl.sv
`timescale 1ns/1ps
module sim_jtag_bscan_ctrl;
  localparam int NI = 4, NO = 4, SW = 8, L = NI + NO, DN = 16;
  localparam logic [3:0] EXT = 4'b0000, SMP = 4'b0010, SOC = 4'b0100,
                         CLP = 4'b0110, HIZ = 4'b1001, BYP = 4'b1111;

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] sys_out = '0;
  logic [SW-1:0] soc_word = '0;
  logic tdo, tdo_oe, bsr_drive, pads_hiz, sys_rst_req;
  logic [NO-1:0] pad_out;

  jtag_bscan_ctrl #(.N_IN(NI), .N_OUT(NO), .SOC_W(SW)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .sys_out(sys_out), .soc_word(soc_word), .pad_out(pad_out),
    .bsr_drive(bsr_drive), .pads_hiz(pads_hiz), .sys_rst_req(sys_rst_req));

  always #2.5 tck = ~tck;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_ins = BYP;
  logic [NO-1:0] m_upd = '0;
  logic s_tdo, s_oe;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    s_tdo = tdo; s_oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  function automatic bit is_bsr(input logic [3:0] i); return i == EXT || i == SMP; endfunction

  function automatic logic [3:0] exp_ctl(input logic [3:0] i);
    // {bsr_drive, pads_hiz, sys_rst_req, 1'b0}
    case (i)
      EXT: return 4'b1010;
      CLP: return 4'b1000;
      HIZ: return 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [DN-1:0] exp_dr(input logic [3:0] i, input logic [DN-1:0] din);
    int len; logic [DN-1:0] cap, r;
    if (is_bsr(i)) begin len = L; cap = DN'({sys_out, pin_in}); end
    else if (i == SOC) begin len = SW; cap = DN'(soc_word); end
    else begin len = 1; cap = '0; end
    for (int k = 0; k < DN; k++) r[k] = (k < len) ? cap[k] : din[k - len];
    return r;
  endfunction

  task automatic scan(input bit ir, input int n, input logic [63:0] din,
                      output logic [63:0] dout, output logic oe_all);
    step(1, 0); if (ir) step(1, 0); step(0, 0); step(0, 0);
    dout = '0; oe_all = 1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo; oe_all &= s_oe;
    end
    step(1, 0); step(0, 0);
    #1;
  endtask

  task automatic check_pins(input string tag);
    logic [3:0] c;
    c = exp_ctl(m_ins);
    chk({tag, " ctl"}, {bsr_drive, pads_hiz, sys_rst_req, 1'b0}, c);
    chk({tag, " pad"}, pad_out, c[3] ? m_upd : sys_out);
  endtask

  task automatic load(input logic [3:0] i, input string tag);
    logic [63:0] d; logic oe;
    scan(1, 4, {60'd0, i}, d, oe);
    chk({tag, " R2 ir capture"}, d[3:0], 4'b0001);
    chk({tag, " R3 oe in shift"}, oe, 1);
    m_ins = i;
    check_pins(tag);
  endtask

  task automatic dr(input string tag, input logic [DN-1:0] din);
    logic [63:0] d; logic oe;
    scan(0, DN, 64'(din), d, oe);
    chk({tag, " path"}, d[DN-1:0], exp_dr(m_ins, din));
    if (is_bsr(m_ins)) m_upd = din[DN-L+NI +: NO];
    check_pins({tag, " R10 after dr"});
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    n_chk++; n_bad++;
    summary();
  end

  initial begin
    int unsigned sd;
    logic [DN-1:0] r;
    sd = $urandom(32'd4711);
    sys_out = 4'hA; pin_in = 4'h3; soc_word = 8'h5C;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset oe", tdo_oe, 0);
    chk("R1 reset ctl", {bsr_drive, pads_hiz, sys_rst_req}, 3'b000);
    chk("R1 reset pad", pad_out, sys_out);
    @(negedge tck); trst_n = 1;
    step(0, 0); #1;
    chk("R3 oe idle", tdo_oe, 0);

    load(SMP, "R5 sample");
    dr("R5 sample", 16'hB6E1);
    sys_out = 4'h6; #1;
    chk("R5 pad follows sys", pad_out, 4'h6);
    load(EXT, "R6 extest");
    chk("R6 latch drive", pad_out, 4'hB);
    dr("R6 extest", 16'h7D29);
    load(CLP, "R8 clamp");
    dr("R10 clamp scan", 16'hFFFF);
    chk("R10 latch held", pad_out, 4'h7);
    load(HIZ, "R7 highz");
    dr("R7 highz", 16'h1234);
    load(SOC, "R9 status");
    dr("R9 status", 16'hC0DE);
    load(4'b0101, "R4 undefined");
    dr("R4 undefined", 16'h8001);
    load(BYP, "R4 bypass");
    dr("R4 bypass", 16'h55AA);

    // R2: instruction not in force while parked in Pause-IR
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, HIZ[i]);
    step(0, 0); step(0, 0); #1;
    chk("R2 pause keeps old", {bsr_drive, pads_hiz, sys_rst_req}, 3'b000);
    step(1, 0); step(1, 0); step(0, 0); #1;
    m_ins = HIZ;
    chk("R2 update applies", {bsr_drive, pads_hiz, sys_rst_req}, 3'b011);

    // R1: five TMS-high edges
    load(EXT, "R1 pre");
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0); #1;
    m_ins = BYP; m_upd = '0;
    chk("R1 tms reset ctl", {bsr_drive, pads_hiz, sys_rst_req}, 3'b000);
    load(CLP, "R1 latch cleared");
    chk("R1 latch zero", pad_out, 4'h0);

    // R1: async reset during a scan
    load(EXT, "R1 async pre");
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    #1; trst_n = 0; #1;
    chk("R1 async oe", tdo_oe, 0);
    chk("R1 async ctl", {bsr_drive, pads_hiz, sys_rst_req}, 3'b000);
    @(negedge tck); trst_n = 1; tms = 1;
    step(0, 0); #1;
    m_ins = BYP; m_upd = '0;

    for (int it = 0; it < 150; it++) begin
      logic [3:0] op;
      case ($urandom_range(0, 6))
        0: op = EXT; 1: op = SMP; 2: op = SOC; 3: op = CLP;
        4: op = HIZ; 5: op = BYP; default: op = 4'($urandom);
      endcase
      pin_in = NI'($urandom); sys_out = NO'($urandom); soc_word = SW'($urandom);
      load(op, "R4 R5 R6 R7 R8 R9 random");
      r = DN'($urandom);
      dr("R4 R5 R6 R9 R10 random", r);
    end
    summary();
  end
endmodule